// File: doc/BRIEF.md
# DPLL Phase Slew Rate Limiter

This block sits between the phase detector of a digital PLL and its loop filter. Each valid sample carries the signed phase difference between the feedback and reference inputs. When the loop changes to a new reference, that difference can jump by a large amount. If the jump went straight to the loop filter, the output phase would move too quickly. The limiter therefore hands the loop filter an error word whose value can only move toward the measured error at a programmed rate. This makes the reference change hitless.

The rate is set as a 16-bit value in nanoseconds per second. On every system clock cycle, the value is multiplied by a fixed-point scale factor and added to a fractional accumulator. The integer part of the accumulator is the number of error LSBs that the output may still move. Each valid sample moves the output toward the input by at most that amount, and the amount moved is taken out of the accumulator. Fractions are carried over from cycle to cycle, so accuracy improves as the rate value grows and as the cycle rate falls. The limiter is bypassed in two cases: when the rate value is zero, which is the reset default, and when no switchover is in progress.

Top module: `phase_slew_limiter`

## Requirements
- R1: After reset, `err_out` is 0 and `err_out_vld` and `clamping` are both low.
- R2: When `slew_limit` is 0, a sample taken with `err_vld` high appears unchanged on `err_out` one cycle later, for every input value, and `clamping` is low.
- R3: When `switch_active` is low, the limiter is bypassed exactly as in R2, whatever the value of `slew_limit`.
- R4: `err_out_vld` is `err_vld` delayed by one cycle. `err_out` holds its value on cycles without a valid sample.
- R5: While limiting, the budget grows by `slew_limit*STEP_SCALE/2^FRAC_W` LSB on every cycle, with the fraction kept. Let edge 0 be the first valid sample that differs from the settled output, and let D be the size of the jump. At a valid edge k, `err_out` has moved min(D, floor(k*slew_limit*STEP_SCALE/2^FRAC_W)) LSB toward the input.
- R6: Movement in the negative direction follows the same law as movement in the positive direction.
- R7: The output never moves past the input and lands exactly on it.
- R8: A jump across the full signed range, from the most negative value to the most positive value and back, moves monotonically with no wraparound.
- R9: Once `err_out` equals the input, the budget is cleared. At the first sample of the next jump, the output does not move, even after idle cycles.
- R10: While limiting, `clamping` is high exactly when `err_out` differs from the last accepted input sample.
- R11: Cycles without a valid sample still add to the budget, so the R5 law holds when k counts every cycle.
- R12: If `switch_active` drops in the middle of a ramp, the next sample passes through unchanged and `clamping` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one limiter tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | ERR_W | Signed measured phase error (feedback minus reference) |
| err_vld | input | 1 | Strobe marking a valid `err_in` sample |
| slew_limit | input | LIM_W | Rate limit in ns/s; 0 bypasses the limiter |
| switch_active | input | 1 | High while a reference switchover is in progress |
| err_out | output | ERR_W | Signed limited phase error to the loop filter |
| err_out_vld | output | 1 | Valid strobe for `err_out` |
| clamping | output | 1 | High while the output is being held back from the input |

## Verification
The bench works out the expected output of each ramp from a closed-form floor law. A design that dropped the fractional carry would fall behind that law on slow rates. A design that did not add budget during idle cycles would lag in the sparse-sample runs. Jumps between the signed extremes show up any wraparound in the difference or step arithmetic, because the output would head the wrong way. Other sequences check that the budget is cleared after landing and that the limiter releases when the switchover flag drops mid-ramp. A design that failed either one would move early on the next jump or stay clamped.

// File: rtl/slew_pkg.sv
package slew_pkg;

  // Operating state of the limiter, derived each cycle from its registers.
  typedef enum logic [1:0] {
    SLW_BYPASS  = 2'd0,
    SLW_SETTLED = 2'd1,
    SLW_SLEWING = 2'd2
  } slew_mode_e;

  // Larger of two widths, used to size intermediate sums.
  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/slew_budget_acc.sv
module slew_budget_acc #(
  parameter int unsigned BUD_W  = 9,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned INC_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [BUD_W-1:0] used,
  input  logic [INC_W-1:0] inc,
  output logic [BUD_W-1:0] budget,
  output logic             acc_full
);
  localparam int unsigned ACC_W = BUD_W + FRAC_W;
  localparam int unsigned SUM_W = slew_pkg::wmax(ACC_W, INC_W) + 1;

  logic [ACC_W-1:0] acc_q;

  // Remove the spent whole LSBs, add this tick's increment, saturate at full scale.
  function automatic logic [ACC_W-1:0] acc_update(
    input logic [ACC_W-1:0] acc,
    input logic             spend,
    input logic [BUD_W-1:0] amount,
    input logic [INC_W-1:0] step
  );
    logic [SUM_W-1:0] rem;
    logic [SUM_W-1:0] sum;
    rem = SUM_W'(acc) - (spend ? (SUM_W'(amount) << FRAC_W) : '0);
    sum = rem + SUM_W'(step);
    if (sum > SUM_W'({ACC_W{1'b1}})) return '1;
    return sum[ACC_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_update(acc_q, take, used, inc);
  end

  assign budget   = acc_q[ACC_W-1:FRAC_W];
  assign acc_full = &acc_q;

  // R11
  acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !take) |=> (acc_q >= $past(acc_q)));

  // R5
  take_within_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (used <= budget));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (budget == '0));

endmodule

// File: rtl/slew_step.sv
module slew_step #(
  parameter int unsigned ERR_W = 8,
  parameter int unsigned BUD_W = ERR_W + 1
) (
  input  logic signed [ERR_W-1:0] cur,
  input  logic signed [ERR_W-1:0] tgt,
  input  logic        [BUD_W-1:0] budget,
  output logic signed [ERR_W-1:0] nxt,
  output logic        [BUD_W-1:0] used,
  output logic                    fits
);
  localparam int unsigned DW = ERR_W + 1;
  localparam int unsigned WW = ERR_W + 2;

  logic signed [DW-1:0] delta;
  logic        [BUD_W-1:0] mag;

  // Absolute size of a signed difference.
  function automatic logic [BUD_W-1:0] err_mag(input logic signed [DW-1:0] d);
    return (d < 0) ? BUD_W'(-d) : BUD_W'(d);
  endfunction

  // Clamp a wide signed value into the signed error range.
  function automatic logic signed [ERR_W-1:0] sat_err(input logic signed [WW-1:0] w);
    logic signed [WW-1:0] hi;
    logic signed [WW-1:0] lo;
    hi = WW'({1'b0, {(ERR_W-1){1'b1}}});
    lo = -hi - 1;
    if (w > hi) return {1'b0, {(ERR_W-1){1'b1}}};
    if (w < lo) return {1'b1, {(ERR_W-1){1'b0}}};
    return w[ERR_W-1:0];
  endfunction

  // Move the current value by amt toward the target direction.
  function automatic logic signed [ERR_W-1:0] move_toward(
    input logic signed [ERR_W-1:0] c,
    input logic                    down,
    input logic        [BUD_W-1:0] amt
  );
    logic signed [WW-1:0] w;
    logic signed [WW-1:0] a;
    a = $signed({1'b0, amt});
    w = down ? (WW'(c) - a) : (WW'(c) + a);
    return sat_err(w);
  endfunction

  always_comb begin
    delta = DW'(tgt) - DW'(cur);
    mag   = err_mag(delta);
    fits  = (mag <= budget);
    used  = fits ? mag : budget;
    nxt   = fits ? tgt : move_toward(cur, delta < 0, budget);
  end

endmodule

// File: rtl/phase_slew_limiter.sv
module phase_slew_limiter #(
  parameter int unsigned ERR_W   = 24,
  parameter int unsigned LIM_W   = 16,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned SCALE_W = 16,
  parameter logic [SCALE_W-1:0] STEP_SCALE = 16'd4295
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic                    err_vld,
  input  logic        [LIM_W-1:0] slew_limit,
  input  logic                    switch_active,
  output logic signed [ERR_W-1:0] err_out,
  output logic                    err_out_vld,
  output logic                    clamping
);
  import slew_pkg::*;

  localparam int unsigned BUD_W = ERR_W + 1;
  localparam int unsigned INC_W = LIM_W + SCALE_W;

  logic signed [ERR_W-1:0] out_q;
  logic signed [ERR_W-1:0] tgt_q;
  logic                    settled_q;
  logic                    vld_q;
  logic                    clamp_q;

  logic                    engaged;
  logic        [INC_W-1:0] inc;
  logic        [BUD_W-1:0] budget;
  logic        [BUD_W-1:0] used;
  logic signed [ERR_W-1:0] nxt;
  logic                    fits;
  logic                    acc_clr;
  logic                    acc_take;
  logic                    acc_full;
  slew_mode_e              mode;

  // Per-tick budget increment in fixed point with FRAC_W fraction bits.
  function automatic logic [INC_W-1:0] tick_step(input logic [LIM_W-1:0] lim);
    return INC_W'(lim) * INC_W'(STEP_SCALE);
  endfunction

  assign engaged  = switch_active && (slew_limit != '0);
  assign inc      = tick_step(slew_limit);
  assign acc_clr  = !engaged || (err_vld ? fits : settled_q);
  assign acc_take = engaged && err_vld && !fits;
  assign mode     = !engaged ? SLW_BYPASS : (settled_q ? SLW_SETTLED : SLW_SLEWING);

  slew_budget_acc #(
    .BUD_W (BUD_W),
    .FRAC_W(FRAC_W),
    .INC_W (INC_W)
  ) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .take    (acc_take),
    .used    (used),
    .inc     (inc),
    .budget  (budget),
    .acc_full(acc_full)
  );

  slew_step #(
    .ERR_W(ERR_W),
    .BUD_W(BUD_W)
  ) u_step (
    .cur   (out_q),
    .tgt   (err_in),
    .budget(budget),
    .nxt   (nxt),
    .used  (used),
    .fits  (fits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q     <= '0;
      tgt_q     <= '0;
      settled_q <= 1'b1;
      vld_q     <= 1'b0;
      clamp_q   <= 1'b0;
    end else begin
      vld_q <= err_vld;
      if (err_vld) tgt_q <= err_in;
      if (!engaged) begin
        clamp_q <= 1'b0;
        if (err_vld) begin
          out_q     <= err_in;
          settled_q <= 1'b1;
        end
      end else if (err_vld) begin
        out_q     <= nxt;
        settled_q <= fits;
        clamp_q   <= !fits;
      end
    end
  end

  assign err_out     = out_q;
  assign err_out_vld = vld_q;
  assign clamping    = clamp_q;

  // R2 R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!engaged && err_vld) |=> ((err_out == $past(err_in)) && !clamping));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |=> $stable(err_out));

  // R4
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_out_vld == $past(err_vld)));

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && err_vld) |=>
      (((int'(err_out) >= int'($past(err_out))) ?
        (int'(err_out) - int'($past(err_out))) :
        (int'($past(err_out)) - int'(err_out))) <= int'($past(budget))));

  // R7
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && err_vld && (err_in >= err_out)) |=> (err_out <= $past(err_in)));

  // R10
  clamp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamping |-> (err_out != tgt_q));

  // R9
  settled_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SLW_SETTLED && !err_vld) |=> (budget == '0));

  // R5
  full_only_slewing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_full |-> (mode != SLW_BYPASS) || !$past(engaged));

endmodule

// File: tb/phase_slew_limiter_bench.sv
module phase_slew_limiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W  = 8;
  localparam int FRAC_W = 4;
  localparam int DIV    = 16;   // 2^FRAC_W with STEP_SCALE = 1

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic signed [ERR_W-1:0] err_in = '0;
  logic                    err_vld = 1'b0;
  logic [15:0]             slew_limit = '0;
  logic                    switch_active = 1'b0;
  logic signed [ERR_W-1:0] err_out;
  logic                    err_out_vld;
  logic                    clamping;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_slew_limiter #(
    .ERR_W(ERR_W), .LIM_W(16), .FRAC_W(FRAC_W), .SCALE_W(4), .STEP_SCALE(4'd1)
  ) u_phase_slew_limiter (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_vld(err_vld),
    .slew_limit(slew_limit), .switch_active(switch_active),
    .err_out(err_out), .err_out_vld(err_out_vld), .clamping(clamping)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int x);
    @(negedge clk);
    err_vld = v;
    err_in  = ERR_W'(x);
    @(posedge clk);
    #1;
  endtask

  // Closed-form ramp: movement after edge k is min(D, floor(k*L/16)).
  task automatic ramp(input int o0, input int x, input int lim, input bit gap,
                      input bit preamble, input string tag);
    int d, s, last, expv;
    if (preamble) begin
      switch_active = 1'b0;
      slew_limit    = 16'(lim);
      cyc(1, o0);
      chk(err_out == o0, "R3 preamble", int'(err_out), o0);
      switch_active = 1'b1;
      cyc(0, o0);
    end
    slew_limit = 16'(lim);
    d    = (x >= o0) ? x - o0 : o0 - x;
    s    = (x >= o0) ? 1 : -1;
    last = o0;
    for (int k = 0; k < 6000; k++) begin
      bit v;
      int rel;
      v = !gap || (k % 3 == 0);
      cyc(v, x);
      rel  = (k * lim) / DIV;
      expv = v ? o0 + s * ((rel < d) ? rel : d) : last;
      chk(err_out == expv, tag, int'(err_out), expv);
      chk(clamping == (expv != x), "R10 clamp flag", int'(clamping), int'(expv != x));
      chk(err_out_vld == v, "R4 valid delay", int'(err_out_vld), int'(v));
      last = expv;
      if (v && expv == x) break;
    end
    chk(err_out == x, "R7 lands on target", int'(err_out), x);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int lims [6] = '{1, 7, 16, 100, 1000, 65535};
    int p0   [6] = '{0, 0, -128, 127, 10, -5};
    int p1   [6] = '{20, -20, 127, -128, 11, -37};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(err_out == 0, "R1 err_out", int'(err_out), 0);
    chk(err_out_vld == 0, "R1 err_out_vld", int'(err_out_vld), 0);
    chk(clamping == 0, "R1 clamping", int'(clamping), 0);

    // R2 zero limit passes every value
    switch_active = 1'b1;
    slew_limit    = '0;
    for (int x = -128; x < 128; x++) begin
      cyc(1, x);
      chk(err_out == x, "R2 bypass value", int'(err_out), x);
      chk(clamping == 0, "R2 no clamp", int'(clamping), 0);
    end
    // R4 hold on idle
    cyc(0, 55);
    chk(err_out == 127, "R4 hold", int'(err_out), 127);
    chk(err_out_vld == 0, "R4 vld low", int'(err_out_vld), 0);

    // R3 inactive switchover bypasses a nonzero limit
    switch_active = 1'b0;
    slew_limit    = 16'd37;
    for (int x = -128; x < 128; x += 5) begin
      cyc(1, x);
      chk(err_out == x, "R3 inactive bypass", int'(err_out), x);
      chk(clamping == 0, "R3 no clamp", int'(clamping), 0);
    end

    // R5 R6 R8 R11 ramps over limits, directions and sparsity
    for (int g = 0; g < 2; g++) begin
      for (int li = 0; li < 6; li++) begin
        for (int pi = 0; pi < 6; pi++) begin
          string tag;
          if (g == 1)                tag = "R11 sparse ramp";
          else if (pi == 2 || pi == 3) tag = "R8 full span";
          else if (p1[pi] < p0[pi])  tag = "R6 negative ramp";
          else                       tag = "R5 positive ramp";
          ramp(p0[pi], p1[pi], lims[li], g[0], 1'b1, tag);
        end
      end
    end

    // R9 budget cleared after landing, even across idle cycles
    ramp(0, 40, 16, 1'b0, 1'b1, "R9 first ramp");
    repeat (10) cyc(0, 40);
    ramp(40, 10, 16, 1'b0, 1'b0, "R9 restart from zero");

    // R12 switchover ends mid-ramp
    switch_active = 1'b0;
    cyc(1, 0);
    switch_active = 1'b1;
    slew_limit    = 16'd16;
    cyc(0, 0);
    repeat (5) cyc(1, 100);
    chk(clamping == 1, "R12 clamping mid ramp", int'(clamping), 1);
    switch_active = 1'b0;
    cyc(1, 100);
    chk(err_out == 100, "R12 release value", int'(err_out), 100);
    chk(clamping == 0, "R12 release clamp", int'(clamping), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule